// File: doc/BRIEF.md
# Component Video Plane Splitter

This block takes an 8-bit parallel 4:2:2 component video stream, in which chroma and luma bytes share one bus, and sorts the bytes into three plane outputs: luma (Y), blue-difference chroma (U) and red-difference chroma (V). Each plane output carries a byte, a linear write address and a valid strobe, so a memory writer can store the planes in separate buffers. Active video is found from embedded four-byte timing codes. An optional 2:1 horizontal decimation halves the samples kept per line.

Two alternate modes bypass plane separation. In raw mode every byte goes out unchanged on a stream port. In message mode the bytes sent by a peer device's video output are packed into words on that same stream port. A three-bit control register selects the mode and the decimation. A written value waits as a pending setting and takes effect only at the next start of field, so a line is never split between settings.

Top module: `vid_plane_demux`

## Requirements
- R1: After reset all valid strobes are low and `cfg_rdata_o` reads 0: video mode without decimation, both pending and active.
- R2: A timing code is the byte run FF, 00, 00, XY. In XY, bit 6 is the field flag F, bit 5 the vertical blanking flag V and bit 4 the line-end flag H. A code with V=0 and H=0 opens the active window. Any other code, or any FF byte, closes it. No byte of a timing code, and no byte outside the active window, reaches a plane.
- R3: In video mode, bytes in the active window repeat in the order Cb, Y0, Cr, Y1 and go to U, Y, V, Y. Each output appears one clock after its input byte, and a byte may arrive on every clock.
- R4: Each plane address is 0 for the first sample kept after a start of field. It then grows by one for each sample kept in that plane, and keeps counting across lines of the same field.
- R5: With decimation on, luma keeps only Y0 of each pixel pair. Chroma keeps Cb and Cr only of the even-numbered pairs. A 720-pixel line gives 360 Y, 180 U and 180 V samples.
- R6: Pixel-pair counting restarts at every code that opens the active window, so the first pair of each line is always pair 0.
- R7: In raw mode (mode code 1), every valid byte, timing bytes included, appears zero-extended on the stream port with an address that grows by one. No plane strobe fires in raw mode.
- R8: In message mode (mode code 2), bytes are packed in order, first byte in the lowest byte lane. A word of MSG_BYTES bytes is emitted when its last byte arrives.
- R9: A write to `cfg_wdata_i` (bits [1:0] mode, bit 2 decimation) only updates the pending setting. The pending setting becomes active at a start of field, which is a timing code whose F differs from the last F seen (taken as 1 at reset). `cfg_rdata_o` returns the pending setting in bits [2:0] and the active setting in bits [5:3].
- R10: A write with mode code 3 is ignored, and the pending setting stays unchanged.
- R11: The byte that carries a start-of-field code is handled under the old setting. After that byte, the stream address restarts at 0 and any partly packed message word is dropped.
- R12: No output strobe fires in the cycle after a clock with `byte_vld_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Multiplexed input byte |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 3 | Control value: [1:0] mode, [2] decimation |
| cfg_rdata_o | output | 6 | [2:0] pending setting, [5:3] active setting |
| y_vld_o | output | 1 | Luma sample valid |
| y_data_o | output | 8 | Luma sample |
| y_addr_o | output | ADDR_W | Luma plane address |
| u_vld_o | output | 1 | Cb sample valid |
| u_data_o | output | 8 | Cb sample |
| u_addr_o | output | ADDR_W | Cb plane address |
| v_vld_o | output | 1 | Cr sample valid |
| v_data_o | output | 8 | Cr sample |
| v_addr_o | output | ADDR_W | Cr plane address |
| s_vld_o | output | 1 | Raw or message word valid |
| s_data_o | output | 8*MSG_BYTES | Raw byte (zero-extended) or packed message word |
| s_addr_o | output | ADDR_W | Stream word address |

## Verification
Full-rate lines with gaps in the valid strobe check the Cb/Y/Cr/Y routing and the address stepping against a model that advances on every clock. A 720-pixel decimated line checks the kept-sample counts. A one-pair line followed by a longer line separates per-line pair counting from free-running counting. Writes placed in the middle of a field, plus a write with the reserved mode code, show that settings change only at a start of field. Raw and message runs that contain timing codes, with a partial word cut off by a start of field, check which setting handles the boundary byte and that the word lanes restart.

// File: rtl/vid_demux_pkg.sv
package vid_demux_pkg;

  typedef enum logic [1:0] {
    MODE_VIDEO = 2'd0,
    MODE_RAW   = 2'd1,
    MODE_MSG   = 2'd2
  } mode_e;

  typedef struct packed {
    logic  sub;
    mode_e mode;
  } cfg_t;

  localparam int PL_Y = 0;
  localparam int PL_U = 1;
  localparam int PL_V = 2;
  localparam int NUM_PLANES = 3;

  localparam logic [7:0] TRS_LEAD = 8'hFF;
  localparam logic [7:0] TRS_ZERO = 8'h00;
  localparam int XY_F_BIT = 6;
  localparam int XY_V_BIT = 5;
  localparam int XY_H_BIT = 4;

endpackage

// File: rtl/vid_trs_detect.sv
module vid_trs_detect
  import vid_demux_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       is_lead_o,
  output logic       code_stb_o,
  output logic       code_f_o,
  output logic       code_v_o,
  output logic       code_h_o
);

  typedef enum logic [1:0] {S_IDLE, S_GOT_FF, S_GOT_00, S_GOT_0000} trs_st_e;
  trs_st_e st_q, st_d;

  assign is_lead_o  = vld_i && (byte_i == TRS_LEAD);
  assign code_stb_o = vld_i && (st_q == S_GOT_0000);
  assign code_f_o   = byte_i[XY_F_BIT];
  assign code_v_o   = byte_i[XY_V_BIT];
  assign code_h_o   = byte_i[XY_H_BIT];

  always_comb begin
    st_d = st_q;
    if (vld_i) begin
      unique case (st_q)
        S_GOT_0000: st_d = S_IDLE;
        S_IDLE:     st_d = (byte_i == TRS_LEAD) ? S_GOT_FF : S_IDLE;
        S_GOT_FF:   st_d = (byte_i == TRS_ZERO) ? S_GOT_00 :
                           (byte_i == TRS_LEAD) ? S_GOT_FF : S_IDLE;
        default:    st_d = (byte_i == TRS_ZERO) ? S_GOT_0000 :
                           (byte_i == TRS_LEAD) ? S_GOT_FF : S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/vid_plane_writer.sv
module vid_plane_writer #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keep_i,
  input  logic              clear_i,
  input  logic [7:0]        byte_i,
  output logic              vld_o,
  output logic [7:0]        data_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      vld_o  <= 1'b0;
      data_o <= '0;
      addr_o <= '0;
    end else begin
      vld_o <= keep_i;
      if (keep_i) begin
        data_o <= byte_i;
        addr_o <= cnt_q;
        cnt_q  <= cnt_q + 1'b1;
      end
      if (clear_i) cnt_q <= '0;
    end
  end

endmodule

// File: rtl/vid_plane_router.sv
module vid_plane_router
  import vid_demux_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  input  logic              is_lead_i,
  input  logic              code_stb_i,
  input  logic              code_v_i,
  input  logic              code_h_i,
  input  logic              field_start_i,
  input  logic              video_en_i,
  input  logic              sub_i,
  output logic [NUM_PLANES-1:0] pl_vld_o,
  output logic [7:0]        pl_data_o [NUM_PLANES],
  output logic [ADDR_W-1:0] pl_addr_o [NUM_PLANES]
);

  logic              active_q;
  logic [LINE_W-1:0] lc_q;
  logic              plain_byte;
  logic              route;
  logic              pair_odd;
  logic [NUM_PLANES-1:0] keep;

  assign plain_byte = vld_i && !code_stb_i && !is_lead_i;
  assign route      = plain_byte && active_q && video_en_i;
  assign pair_odd   = lc_q[2];

  always_comb begin
    keep = '0;
    if (route) begin
      unique case (lc_q[1:0])
        2'd0:    keep[PL_U] = !sub_i || !pair_odd;
        2'd1:    keep[PL_Y] = 1'b1;
        2'd2:    keep[PL_V] = !sub_i || !pair_odd;
        default: keep[PL_Y] = !sub_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      lc_q     <= '0;
    end else if (vld_i) begin
      if (code_stb_i) begin
        active_q <= !code_v_i && !code_h_i;
        if (!code_v_i && !code_h_i) lc_q <= '0;
      end else if (is_lead_i) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        lc_q <= lc_q + 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    vid_plane_writer #(.ADDR_W(ADDR_W)) u_wr (
      .clk     (clk),
      .rst     (rst),
      .keep_i  (keep[p]),
      .clear_i (field_start_i),
      .byte_i  (byte_i),
      .vld_o   (pl_vld_o[p]),
      .data_o  (pl_data_o[p]),
      .addr_o  (pl_addr_o[p])
    );
  end

  // R3: at most one plane is written per cycle
  a_r3_one_plane: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pl_vld_o));

  // R2: a lead byte of a timing code never reaches a plane
  a_r2_lead_blocked: assert property (@(posedge clk) disable iff (rst)
    $past(vld_i && byte_i == TRS_LEAD) |-> (pl_vld_o == '0));

endmodule

// File: rtl/vid_stream_packer.sv
module vid_stream_packer #(
  parameter int ADDR_W    = 16,
  parameter int MSG_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_i,
  input  logic [7:0]             byte_i,
  input  logic                   raw_en_i,
  input  logic                   msg_en_i,
  input  logic                   field_start_i,
  output logic                   s_vld_o,
  output logic [8*MSG_BYTES-1:0] s_data_o,
  output logic [ADDR_W-1:0]      s_addr_o
);

  localparam int WORD_W = 8 * MSG_BYTES;
  localparam int LANE_W = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;

  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [ADDR_W-1:0] cnt_q;
  logic              last_lane;
  logic              emit;

  assign last_lane = (lane_q == LANE_W'(MSG_BYTES - 1));
  assign emit      = vld_i && (raw_en_i || (msg_en_i && last_lane));

  always_comb begin
    acc_d = acc_q;
    acc_d[lane_q*8 +: 8] = byte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q   <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      s_vld_o  <= 1'b0;
      s_data_o <= '0;
      s_addr_o <= '0;
    end else begin
      s_vld_o <= emit;
      if (emit) begin
        s_data_o <= raw_en_i ? WORD_W'(byte_i) : acc_d;
        s_addr_o <= cnt_q;
        cnt_q    <= cnt_q + 1'b1;
      end
      if (vld_i && msg_en_i) begin
        acc_q  <= acc_d;
        lane_q <= last_lane ? '0 : lane_q + 1'b1;
      end
      if (field_start_i) begin
        cnt_q  <= '0;
        lane_q <= '0;
      end
    end
  end

  // R8: lane index stays inside the word
  a_r8_lane_range: assert property (@(posedge clk) disable iff (rst)
    int'(lane_q) < MSG_BYTES);

  // R11: a start of field leaves the next message word beginning at lane 0
  a_r11_lane_restart: assert property (@(posedge clk) disable iff (rst)
    $past(field_start_i) |-> (lane_q == '0));

endmodule

// File: rtl/vid_plane_demux.sv
module vid_plane_demux
  import vid_demux_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LINE_W    = 12,
  parameter int MSG_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   byte_vld_i,
  input  logic [7:0]             byte_i,
  input  logic                   cfg_wr_i,
  input  logic [2:0]             cfg_wdata_i,
  output logic [5:0]             cfg_rdata_o,
  output logic                   y_vld_o,
  output logic [7:0]             y_data_o,
  output logic [ADDR_W-1:0]      y_addr_o,
  output logic                   u_vld_o,
  output logic [7:0]             u_data_o,
  output logic [ADDR_W-1:0]      u_addr_o,
  output logic                   v_vld_o,
  output logic [7:0]             v_data_o,
  output logic [ADDR_W-1:0]      v_addr_o,
  output logic                   s_vld_o,
  output logic [8*MSG_BYTES-1:0] s_data_o,
  output logic [ADDR_W-1:0]      s_addr_o
);

  cfg_t pend_q, act_q;
  logic f_q;

  logic is_lead, code_stb, code_f, code_v, code_h;
  logic field_start;
  logic [NUM_PLANES-1:0] pl_vld;
  logic [7:0]            pl_data [NUM_PLANES];
  logic [ADDR_W-1:0]     pl_addr [NUM_PLANES];

  vid_trs_detect u_trs (
    .clk        (clk),
    .rst        (rst),
    .vld_i      (byte_vld_i),
    .byte_i     (byte_i),
    .is_lead_o  (is_lead),
    .code_stb_o (code_stb),
    .code_f_o   (code_f),
    .code_v_o   (code_v),
    .code_h_o   (code_h)
  );

  assign field_start = code_stb && (code_f != f_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '{sub: 1'b0, mode: MODE_VIDEO};
      act_q  <= '{sub: 1'b0, mode: MODE_VIDEO};
      f_q    <= 1'b1;
    end else begin
      if (cfg_wr_i && cfg_wdata_i[1:0] != 2'b11)
        pend_q <= '{sub: cfg_wdata_i[2], mode: mode_e'(cfg_wdata_i[1:0])};
      if (field_start) begin
        act_q <= pend_q;
        f_q   <= code_f;
      end
    end
  end

  assign cfg_rdata_o = {act_q, pend_q};

  vid_plane_router #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_route (
    .clk           (clk),
    .rst           (rst),
    .vld_i         (byte_vld_i),
    .byte_i        (byte_i),
    .is_lead_i     (is_lead),
    .code_stb_i    (code_stb),
    .code_v_i      (code_v),
    .code_h_i      (code_h),
    .field_start_i (field_start),
    .video_en_i    (act_q.mode == MODE_VIDEO),
    .sub_i         (act_q.sub),
    .pl_vld_o      (pl_vld),
    .pl_data_o     (pl_data),
    .pl_addr_o     (pl_addr)
  );

  vid_stream_packer #(.ADDR_W(ADDR_W), .MSG_BYTES(MSG_BYTES)) u_pack (
    .clk           (clk),
    .rst           (rst),
    .vld_i         (byte_vld_i),
    .byte_i        (byte_i),
    .raw_en_i      (act_q.mode == MODE_RAW),
    .msg_en_i      (act_q.mode == MODE_MSG),
    .field_start_i (field_start),
    .s_vld_o       (s_vld_o),
    .s_data_o      (s_data_o),
    .s_addr_o      (s_addr_o)
  );

  assign y_vld_o  = pl_vld[PL_Y];
  assign y_data_o = pl_data[PL_Y];
  assign y_addr_o = pl_addr[PL_Y];
  assign u_vld_o  = pl_vld[PL_U];
  assign u_data_o = pl_data[PL_U];
  assign u_addr_o = pl_addr[PL_U];
  assign v_vld_o  = pl_vld[PL_V];
  assign v_data_o = pl_data[PL_V];
  assign v_addr_o = pl_addr[PL_V];

  // R9: the active setting only moves at a start of field
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(field_start) |-> $stable(act_q));

  // R10: a reserved mode code never reaches the pending setting
  a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_wr_i && cfg_wdata_i[1:0] == 2'b11) |-> $stable(pend_q));

  // R12: no strobe follows a cycle without an input byte
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_vld_i) |-> !(y_vld_o || u_vld_o || v_vld_o || s_vld_o));

  // R7: plane and stream outputs never fire together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({y_vld_o, u_vld_o, v_vld_o, s_vld_o}));

endmodule

// File: tb/vid_plane_demux_tb_top.sv
module vid_plane_demux_tb_top;

  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_vld = 1'b0;
  logic [7:0] byte_d = 8'h00;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = 3'd0;
  logic [5:0] cfg_rdata;
  logic y_vld, u_vld, v_vld, s_vld;
  logic [7:0] y_data, u_data, v_data;
  logic [AW-1:0] y_addr, u_addr, v_addr, s_addr;
  logic [31:0] s_data;

  always #5 clk = ~clk;

  vid_plane_demux dut_i (
    .clk(clk), .rst(rst), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .y_vld_o(y_vld), .y_data_o(y_data), .y_addr_o(y_addr),
    .u_vld_o(u_vld), .u_data_o(u_data), .u_addr_o(u_addr),
    .v_vld_o(v_vld), .v_data_o(v_data), .v_addr_o(v_addr),
    .s_vld_o(s_vld), .s_data_o(s_data), .s_addr_o(s_addr)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pre, m_lc, m_ya, m_ua, m_va, m_sa, m_lane;
  int m_mode, m_sub, p_mode, p_sub;
  bit m_f, m_act;
  logic [31:0] m_word;
  bit e_yv, e_uv, e_vv, e_sv;
  int e_yd, e_ud, e_vd, e_ya, e_ua, e_va, e_sa;
  logic [31:0] e_sd;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_lc = 0; m_ya = 0; m_ua = 0; m_va = 0; m_sa = 0; m_lane = 0;
      m_mode = 0; m_sub = 0; p_mode = 0; p_sub = 0; m_f = 1; m_act = 0;
      m_word = 0; e_yv = 0; e_uv = 0; e_vv = 0; e_sv = 0;
    end else begin
      bit code, fs;
      e_yv = 0; e_uv = 0; e_vv = 0; e_sv = 0;
      if (byte_vld) begin
        code = (m_pre == 3);
        fs = code && (byte_d[6] != m_f);
        if (m_mode == 1) begin
          e_sv = 1; e_sd = {24'h0, byte_d}; e_sa = m_sa; m_sa++;
        end else if (m_mode == 2) begin
          m_word[m_lane*8 +: 8] = byte_d;
          if (m_lane == 3) begin
            e_sv = 1; e_sd = m_word; e_sa = m_sa; m_sa++; m_lane = 0;
          end else m_lane++;
        end
        if (code) begin
          m_act = !byte_d[5] && !byte_d[4];
          if (m_act) m_lc = 0;
        end else if (byte_d == 8'hFF) begin
          m_act = 0;
        end else if (m_act) begin
          if (m_mode == 0) begin
            int ph, pr;
            ph = m_lc % 4; pr = (m_lc / 4) % 2;
            if (ph == 0 && (m_sub == 0 || pr == 0)) begin e_uv = 1; e_ud = byte_d; e_ua = m_ua; m_ua++; end
            if (ph == 2 && (m_sub == 0 || pr == 0)) begin e_vv = 1; e_vd = byte_d; e_va = m_va; m_va++; end
            if (ph == 1 || (ph == 3 && m_sub == 0)) begin e_yv = 1; e_yd = byte_d; e_ya = m_ya; m_ya++; end
          end
          m_lc++;
        end
        if (m_pre == 3) m_pre = 0;
        else if (byte_d == 8'hFF) m_pre = 1;
        else if (byte_d == 8'h00 && m_pre > 0) m_pre++;
        else m_pre = 0;
        if (fs) begin
          m_f = byte_d[6]; m_mode = p_mode; m_sub = p_sub;
          m_ya = 0; m_ua = 0; m_va = 0; m_sa = 0; m_lane = 0;
        end
      end
      if (cfg_wr && cfg_wdata[1:0] != 2'b11) begin
        p_mode = cfg_wdata[1:0]; p_sub = cfg_wdata[2];
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int cnt_y = 0, cnt_u = 0, cnt_v = 0, cnt_s = 0;
  logic [7:0] u_log [$];
  logic [31:0] s_log [$];
  int sa_log [$];

  always @(negedge clk) begin
    if (!rst) begin
      chk(y_vld == e_yv, "R2 R12", "y_vld", y_vld, e_yv);
      chk(u_vld == e_uv, "R2 R12", "u_vld", u_vld, e_uv);
      chk(v_vld == e_vv, "R2 R12", "v_vld", v_vld, e_vv);
      chk(s_vld == e_sv, "R7 R12", "s_vld", s_vld, e_sv);
      if (e_yv && y_vld) begin
        chk(y_data == e_yd[7:0], "R3 R5", "y_data", y_data, e_yd);
        chk(y_addr == AW'(e_ya), "R4", "y_addr", y_addr, e_ya);
      end
      if (e_uv && u_vld) begin
        chk(u_data == e_ud[7:0], "R3 R6", "u_data", u_data, e_ud);
        chk(u_addr == AW'(e_ua), "R4", "u_addr", u_addr, e_ua);
      end
      if (e_vv && v_vld) begin
        chk(v_data == e_vd[7:0], "R3 R6", "v_data", v_data, e_vd);
        chk(v_addr == AW'(e_va), "R4", "v_addr", v_addr, e_va);
      end
      if (e_sv && s_vld) begin
        chk(s_data == e_sd, "R7 R8 R11", "s_data", s_data, e_sd);
        chk(s_addr == AW'(e_sa), "R11", "s_addr", s_addr, e_sa);
      end
      if (y_vld) cnt_y++;
      if (u_vld) begin cnt_u++; u_log.push_back(u_data); end
      if (v_vld) cnt_v++;
      if (s_vld) begin cnt_s++; s_log.push_back(s_data); sa_log.push_back(int'(s_addr)); end
    end
  end

  // ---------------- stimulus helpers ----------------
  int gap = 0;

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_d = b; cfg_wr = 1'b0;
    gap++;
    if (gap % 7 == 0) begin
      @(negedge clk);
      byte_vld = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b0; cfg_wr = 1'b0;
    end
    #1;
  endtask

  task automatic code(input logic [7:0] xy);
    send(8'hFF); send(8'h00); send(8'h00); send(xy);
  endtask

  task automatic cfg(input logic [2:0] w);
    @(negedge clk);
    byte_vld = 1'b0; cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  // one line: start code, npix pixels, end code, a few blanking bytes
  task automatic line(input bit f, input int npix, input logic [7:0] cbase);
    code({1'b1, f, 2'b00, 4'h0});
    for (int i = 0; i < npix / 2; i++) begin
      send(cbase + 8'(i % 32));
      send(8'h80 + 8'(i % 64));
      send(8'hC0 - 8'(i % 32));
      send(8'h20 + 8'(i % 64));
    end
    code({1'b1, f, 2'b01, 4'h0});
    send(8'h80); send(8'h10); send(8'h80); send(8'h10);
  endtask

  int by, bu, bv, bs, bl;

  task automatic snap();
    by = cnt_y; bu = cnt_u; bv = cnt_v; bs = cnt_s; bl = u_log.size();
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(cfg_rdata == 6'h00, "R1", "cfg_rdata", cfg_rdata, 0);
    chk(!(y_vld | u_vld | v_vld | s_vld), "R1", "strobes", y_vld | u_vld | v_vld | s_vld, 0);

    // R2: blanking codes and bytes only, no plane output
    snap();
    code(8'hA0); send(8'h80); send(8'h10); code(8'hB0);
    idle(2);
    chk(cnt_y == by && cnt_u == bu, "R2", "blanking writes", cnt_y - by, 0);

    // R3 R4: full-rate lines in field F=0 (first code starts the field)
    snap();
    line(1'b0, 16, 8'h40);
    idle(2);
    chk(cnt_y - by == 16, "R3", "y count full rate", cnt_y - by, 16);
    chk(cnt_u - bu == 8, "R3", "u count full rate", cnt_u - bu, 8);
    chk(cnt_v - bv == 8, "R3", "v count full rate", cnt_v - bv, 8);
    line(1'b0, 10, 8'h50);
    idle(2);

    // R9: decimation written mid-field stays pending
    cfg(3'b100);
    chk(cfg_rdata == 6'h04, "R9", "pending only", cfg_rdata, 6'h04);
    snap();
    line(1'b0, 16, 8'h44);
    idle(2);
    chk(cfg_rdata[5:3] == 3'b000, "R9", "active unchanged", cfg_rdata, 0);
    chk(cnt_y - by == 16, "R9", "still full rate", cnt_y - by, 16);

    // R10: reserved mode code is ignored
    cfg(3'b011);
    chk(cfg_rdata == 6'h04, "R10", "reserved write", cfg_rdata, 6'h04);

    // R5: new field activates decimation; 720-pixel line
    snap();
    line(1'b1, 720, 8'h40);
    idle(2);
    chk(cfg_rdata == 6'h24, "R9", "active after field", cfg_rdata, 6'h24);
    chk(cnt_y - by == 360, "R5", "y decimated", cnt_y - by, 360);
    chk(cnt_u - bu == 180, "R5", "u decimated", cnt_u - bu, 180);
    chk(cnt_v - bv == 180, "R5", "v decimated", cnt_v - bv, 180);

    // R6: one-pair line then a line whose first Cb must be kept
    line(1'b1, 2, 8'h30);
    idle(2);
    snap();
    line(1'b1, 8, 8'h41);
    idle(2);
    chk(u_log.size() > bl && u_log[bl] == 8'h41, "R6", "first Cb of line",
        (u_log.size() > bl) ? u_log[bl] : 0, 8'h41);
    chk(cnt_u - bu == 2, "R6", "u count 4 pairs", cnt_u - bu, 2);

    // R7: raw mode from the next field
    cfg(3'b001);
    snap();
    code(8'h80);
    for (int i = 0; i < 8; i++) send(8'h10 + 8'(i));
    code(8'h90);
    idle(2);
    chk(cnt_s - bs == 12, "R7", "raw byte count", cnt_s - bs, 12);
    chk(cnt_y == by, "R7", "no plane in raw", cnt_y - by, 0);

    // R11: field code under raw forwards its own byte, then message mode
    cfg(3'b010);
    snap();
    code(8'hC0);
    idle(2);
    chk(cnt_s - bs == 4 && s_log[s_log.size()-1] == 32'hC0, "R11", "code byte raw",
        s_log[s_log.size()-1], 32'hC0);

    // R8: message packing
    snap();
    send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'h55); send(8'h66);
    idle(2);
    chk(cnt_s - bs == 1 && s_log[bs] == 32'h44332211, "R8", "packed word",
        s_log[s_log.size()-1], 32'h44332211);
    chk(sa_log[bs] == 0, "R8", "first word addr", sa_log[bs], 0);

    // R11: field start drops partial word, next word restarts at address 0
    snap();
    code(8'h80);
    send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4);
    idle(2);
    chk(cnt_s - bs == 2, "R11", "word count", cnt_s - bs, 2);
    chk(s_log[bs] == 32'h00FF6655, "R8", "boundary word", s_log[bs], 32'h00FF6655);
    chk(s_log[bs+1] == 32'hA4A3A2A1 && sa_log[bs+1] == 0, "R11", "restart word",
        s_log[bs+1], 32'hA4A3A2A1);

    // back to video; the code that switches also opens the line
    cfg(3'b000);
    snap();
    code(8'hC0);
    send(8'h45); send(8'h81); send(8'h46); send(8'h82);
    code(8'hD0);
    idle(2);
    chk(cnt_s - bs == 1 && s_log[bs] == 32'hC00000FF, "R11", "last msg word",
        s_log[s_log.size()-1], 32'hC00000FF);
    chk(cnt_y - by == 2 && cnt_u - bu == 1, "R3", "video resumes", cnt_y - by, 2);

    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule